// File: doc/BRIEF.md
# Eight-Level Preemptive Priority Interrupt Controller

This block decides which interrupt level a small real-time control processor should be running. Eight maskable levels are provided, and level 0 is the most urgent. A level becomes pending when its external request line or its timer event line shows a rising edge, or when software writes that level's number into the trigger port. The block keeps three sets of state: the pending bits, a mask, and an in-service vector that records the nested levels the processor has been sent to. When a pending, unmasked level outranks everything now in service, the block raises a one-cycle preempt request and reports the granted level. A lower-ranked request waits until the levels above it have finished.

The processor signals that a handler has finished with an end-of-service strobe. This retires the most urgent in-service entry, so the interrupted level becomes current again. A separate power-fail request ranks above all eight levels and ignores the mask. While it is in service, no maskable level can preempt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset there is no pending, masked or in-service level, `preempt` is low and `cur_valid` and `cur_pf` are low.
- R2: When several unmasked levels are pending, the one with the smallest number is granted first (0 is the highest priority).
- R3: If a level's request edge is sampled at clock k and that level outranks every level in service, `preempt` is high for the single cycle after clock k+1. In that same cycle `grant_lvl` and `cur_lvl` carry the level and `grant_pf` is low.
- R4: A request at a level equal to or lower in priority than the current level raises no `preempt`. It stays pending and is granted once every in-service level above it has ended.
- R5: An `eos` pulse clears the in-service entry with the highest priority, and `cur_lvl` returns to the level it interrupted. When nothing remains in service, `cur_valid` goes low.
- R6: `sw_wr` with `sw_lvl` makes level `sw_lvl` pending, exactly as a hardware edge does. A software trigger and a hardware edge on one level in the same cycle produce a single pending entry and so a single grant.
- R7: Pending bits are set only on a rising edge of `hw_req | tmr_evt`. A request held high produces exactly one grant.
- R8: `mask_wr` loads `mask_val` into the mask, where bit i set masks level i. A masked level still latches its request but is not granted until it is unmasked. It is then granted on the second clock after the mask write.
- R9: A rising edge of `pf_req` is granted with `grant_pf` high. The grant happens even when every level is masked and even when level 0 is in service. While power-fail is in service, no maskable level is granted, and the next `eos` clears power-fail first.
- R10: Each grant produces exactly one single-cycle `preempt`. A new `preempt` appears only when a request of higher priority than the current level becomes eligible.
- R11: If `eos` and an eligible pending level fall in the same cycle, the grant decision uses the in-service state after the `eos`. A waiting level of lower priority is therefore granted at that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NUM_LVL | External request per level, edge-sensitive |
| tmr_evt | input | NUM_LVL | Timer event per level, edge-sensitive |
| sw_wr | input | 1 | Software trigger write strobe |
| sw_lvl | input | LVL_W | Level raised by a software trigger write |
| mask_wr | input | 1 | Mask register write strobe |
| mask_val | input | NUM_LVL | New mask value, bit set masks that level |
| eos | input | 1 | End-of-service strobe from the processor |
| pf_req | input | 1 | Power-fail/auto-restart request, edge-sensitive, unmaskable |
| preempt | output | 1 | One-cycle request to preempt the running program |
| grant_lvl | output | LVL_W | Level of the most recent maskable grant |
| grant_pf | output | 1 | High when the latest grant was power-fail |
| cur_valid | output | 1 | Some level or power-fail is in service |
| cur_lvl | output | LVL_W | Highest-priority maskable level in service |
| cur_pf | output | 1 | Power-fail is in service |

## Verification
The delicate overlap is between an end-of-service strobe and a grant in the same clock. The strobe frees the current level, and in that same edge a waiting level of lower priority must be granted against the reduced in-service state. The bench provokes this in every ordered pair of levels: it starts one level, raises a lower-priority one, and then pulses `eos`. It expects `preempt` with the waiting level on the very next sample. A second overlap, a software write and a hardware edge on one level together, is judged by counting that a single grant follows and that the level is quiet after its one service.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // Width of a level index; never below one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Grant kinds held in the grant register.
   typedef enum logic [0:0] {
      GK_LEVEL = 1'b0,
      GK_PFAIL = 1'b1
   } grant_kind_e;

endpackage

// File: rtl/prio_irq_pick.sv
// Finds the lowest-numbered set bit of a vector (the most urgent level).
module prio_irq_pick #(
   parameter int unsigned N = 8,
   parameter int unsigned W = prio_irq_pkg::idx_bits(N)
) (
   input  logic [N-1:0] vec,
   output logic         any,
   output logic [W-1:0] idx
);
   logic [N:0]   seen;
   logic [N-1:0] first;

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign seen[g+1] = seen[g] | vec[g];
      assign first[g]  = vec[g] & ~seen[g];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (first[i]) idx = idx | W'(i);
      end
   end
endmodule

// File: rtl/prio_irq_src.sv
// Turns hardware, timer and software sources into per-level set pulses.
module prio_irq_src #(
   parameter int unsigned N          = 8,
   parameter int unsigned W          = prio_irq_pkg::idx_bits(N),
   parameter bit          SW_TRIG_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_req,
   input  logic [N-1:0] tmr_evt,
   input  logic         sw_wr,
   input  logic [W-1:0] sw_lvl,
   input  logic         pf_req,
   output logic [N-1:0] set_vec,
   output logic         pf_set
);
   logic [N-1:0] line_now;
   logic [N-1:0] line_q;
   logic [N-1:0] sw_hit;
   logic         pf_q;

   assign line_now = hw_req | tmr_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         pf_q   <= 1'b0;
      end else begin
         line_q <= line_now;
         pf_q   <= pf_req;
      end
   end

   if (SW_TRIG_EN) begin : g_sw
      for (genvar g = 0; g < N; g++) begin : g_dec
         assign sw_hit[g] = sw_wr && (sw_lvl == W'(g));
      end
   end else begin : g_nosw
      assign sw_hit = '0;
   end

   for (genvar g = 0; g < N; g++) begin : g_edge
      assign set_vec[g] = (line_now[g] & ~line_q[g]) | sw_hit[g];
   end

   assign pf_set = pf_req & ~pf_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int unsigned NUM_LVL    = 8,
   parameter bit          SW_TRIG_EN = 1'b1,
   localparam int unsigned LVL_W     = prio_irq_pkg::idx_bits(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] hw_req,
   input  logic [NUM_LVL-1:0] tmr_evt,
   input  logic               sw_wr,
   input  logic [LVL_W-1:0]   sw_lvl,
   input  logic               mask_wr,
   input  logic [NUM_LVL-1:0] mask_val,
   input  logic               eos,
   input  logic               pf_req,
   output logic               preempt,
   output logic [LVL_W-1:0]   grant_lvl,
   output logic               grant_pf,
   output logic               cur_valid,
   output logic [LVL_W-1:0]   cur_lvl,
   output logic               cur_pf
);
   import prio_irq_pkg::*;

   if (NUM_LVL < 2 || NUM_LVL > 64) begin : g_bad_cfg
      $error("prio_irq_ctrl: NUM_LVL must lie in 2..64");
   end

   // State
   logic [NUM_LVL-1:0] pend_q, mask_q, insvc_q;
   logic               pf_pend_q, pf_insvc_q;
   logic               preempt_q;
   logic [LVL_W-1:0]   grant_q;
   grant_kind_e        kind_q;

   // Source capture
   logic [NUM_LVL-1:0] set_vec;
   logic               pf_set;

   prio_irq_src #(.N(NUM_LVL), .W(LVL_W), .SW_TRIG_EN(SW_TRIG_EN)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_req  (hw_req),
      .tmr_evt (tmr_evt),
      .sw_wr   (sw_wr),
      .sw_lvl  (sw_lvl),
      .pf_req  (pf_req),
      .set_vec (set_vec),
      .pf_set  (pf_set)
   );

   // Current level, before end-of-service
   logic             cur_any;
   logic [LVL_W-1:0] cur_idx;

   prio_irq_pick #(.N(NUM_LVL), .W(LVL_W)) u_cur (
      .vec (insvc_q),
      .any (cur_any),
      .idx (cur_idx)
   );

   // End-of-service retires power-fail first, else the current level
   logic               eos_pf, eos_lvl;
   logic [NUM_LVL-1:0] eos_clr;
   logic [NUM_LVL-1:0] insvc_post;
   logic               pf_insvc_post;

   assign eos_pf        = eos & pf_insvc_q;
   assign eos_lvl       = eos & ~pf_insvc_q & cur_any;
   assign eos_clr       = eos_lvl ? (NUM_LVL'(1) << cur_idx) : '0;
   assign insvc_post    = insvc_q & ~eos_clr;
   assign pf_insvc_post = pf_insvc_q & ~eos_pf;

   logic             post_any;
   logic [LVL_W-1:0] post_idx;

   prio_irq_pick #(.N(NUM_LVL), .W(LVL_W)) u_post (
      .vec (insvc_post),
      .any (post_any),
      .idx (post_idx)
   );

   // Best eligible pending level
   logic [NUM_LVL-1:0] eligible;
   logic               el_any;
   logic [LVL_W-1:0]   el_idx;

   assign eligible = pend_q & ~mask_q;

   prio_irq_pick #(.N(NUM_LVL), .W(LVL_W)) u_elig (
      .vec (eligible),
      .any (el_any),
      .idx (el_idx)
   );

   // Grant decision
   logic               take_pf, take_lvl;
   logic [NUM_LVL-1:0] take_vec;

   assign take_pf  = pf_pend_q & ~pf_insvc_post;
   assign take_lvl = ~take_pf & ~pf_insvc_post & el_any &
                     (~post_any | (el_idx < post_idx));
   assign take_vec = take_lvl ? (NUM_LVL'(1) << el_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= '0;
         mask_q     <= '0;
         insvc_q    <= '0;
         pf_pend_q  <= 1'b0;
         pf_insvc_q <= 1'b0;
         preempt_q  <= 1'b0;
         grant_q    <= '0;
         kind_q     <= GK_LEVEL;
      end else begin
         pend_q     <= (pend_q & ~take_vec) | set_vec;
         insvc_q    <= insvc_post | take_vec;
         pf_pend_q  <= (pf_pend_q & ~take_pf) | pf_set;
         pf_insvc_q <= pf_insvc_post | take_pf;
         preempt_q  <= take_pf | take_lvl;
         if (mask_wr) mask_q <= mask_val;
         if (take_lvl) begin
            grant_q <= el_idx;
            kind_q  <= GK_LEVEL;
         end else if (take_pf) begin
            kind_q  <= GK_PFAIL;
         end
      end
   end

   assign preempt   = preempt_q;
   assign grant_lvl = grant_q;
   assign grant_pf  = (kind_q == GK_PFAIL);
   assign cur_valid = cur_any | pf_insvc_q;
   assign cur_lvl   = cur_idx;
   assign cur_pf    = pf_insvc_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int unsigned NUM_LVL = 8,
   parameter int unsigned LVL_W   = prio_irq_pkg::idx_bits(NUM_LVL)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               eos,
   input logic               preempt,
   input logic [LVL_W-1:0]   grant_lvl,
   input logic               grant_pf,
   input logic               cur_valid,
   input logic [LVL_W-1:0]   cur_lvl,
   input logic               cur_pf,
   input logic [NUM_LVL-1:0] mask_q
);
   // R3: a maskable grant becomes the current level at once
   assert_grant_current_R3: assert property (@(posedge clk) disable iff (!rst_n)
      preempt && !grant_pf |-> cur_valid && (cur_lvl == grant_lvl));

   // R3: without an end-of-service, a preempting level outranks the old one
   assert_grant_outranks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      preempt && !grant_pf && $past(cur_valid) && !$past(cur_pf) && !$past(eos)
      |-> grant_lvl < $past(cur_lvl));

   // R8: a level masked in the deciding cycle is never granted
   assert_masked_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      preempt && !grant_pf |-> !$past(mask_q[grant_lvl]));

   // R9: nothing preempts a power-fail service already running
   assert_pf_unpreempted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cur_pf && $past(cur_pf) |-> !preempt);

   // R5: end-of-service never leaves the same or a more urgent level current
   assert_eos_retires_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eos) && $past(cur_valid) && !$past(cur_pf) && !preempt
      |-> !cur_valid || (cur_lvl > $past(cur_lvl)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eos       (eos),
   .preempt   (preempt),
   .grant_lvl (grant_lvl),
   .grant_pf  (grant_pf),
   .cur_valid (cur_valid),
   .cur_lvl   (cur_lvl),
   .cur_pf    (cur_pf),
   .mask_q    (mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   localparam int N = 8;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] hw_req = '0, tmr_evt = '0, mask_val = '0;
   logic         sw_wr = 1'b0, mask_wr = 1'b0, eos = 1'b0, pf_req = 1'b0;
   logic [W-1:0] sw_lvl = '0;
   logic         preempt, grant_pf, cur_valid, cur_pf;
   logic [W-1:0] grant_lvl, cur_lvl;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl #(.NUM_LVL(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .tmr_evt(tmr_evt),
      .sw_wr(sw_wr), .sw_lvl(sw_lvl), .mask_wr(mask_wr), .mask_val(mask_val),
      .eos(eos), .pf_req(pf_req), .preempt(preempt), .grant_lvl(grant_lvl),
      .grant_pf(grant_pf), .cur_valid(cur_valid), .cur_lvl(cur_lvl), .cur_pf(cur_pf)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_hw(input int l);
      hw_req[l] = 1'b1; step(); hw_req[l] = 1'b0;
   endtask

   task automatic pulse_tmr(input int l);
      tmr_evt[l] = 1'b1; step(); tmr_evt[l] = 1'b0;
   endtask

   task automatic sw_trig(input int l);
      sw_wr = 1'b1; sw_lvl = W'(l); step(); sw_wr = 1'b0;
   endtask

   task automatic do_eos();
      eos = 1'b1; step(); eos = 1'b0;
   endtask

   task automatic set_mask(input logic [N-1:0] m);
      mask_wr = 1'b1; mask_val = m; step(); mask_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 preempt", preempt, 0);
      chk("R1 cur_valid", cur_valid, 0);
      chk("R1 cur_pf", cur_pf, 0);

      // R7 held request: one grant only
      hw_req[5] = 1'b1; step();
      chk("R7 no preempt yet", preempt, 0);
      step();
      chk("R3 preempt lvl5", preempt, 1);
      chk("R3 grant lvl5", grant_lvl, 5);
      chk("R3 cur lvl5", cur_lvl, 5);
      step();
      chk("R10 preempt single cycle", preempt, 0);
      step();
      chk("R7 held gives no regrant", preempt, 0);
      hw_req[5] = 1'b0;

      // R3 nesting via timer event
      pulse_tmr(2); step();
      chk("R3 preempt lvl2", preempt, 1);
      chk("R3 cur lvl2", cur_lvl, 2);
      // R4 lower level waits
      pulse_hw(6);
      for (int i = 0; i < 3; i++) begin
         chk("R4 lower no preempt", preempt, 0);
         step();
      end
      chk("R4 cur still 2", cur_lvl, 2);
      do_eos();
      chk("R5 resume lvl5", cur_lvl, 5);
      chk("R5 no preempt", preempt, 0);
      do_eos();
      chk("R11 grant with eos", preempt, 1);
      chk("R11 grant lvl6", grant_lvl, 6);
      do_eos();
      chk("R5 idle", cur_valid, 0);

      // R6 collapse and R2 ordering
      sw_wr = 1'b1; sw_lvl = 3'd3; hw_req[3] = 1'b1; hw_req[4] = 1'b1;
      step();
      sw_wr = 1'b0; hw_req[3] = 1'b0; hw_req[4] = 1'b0;
      step();
      chk("R2 grant lowest", grant_lvl, 3);
      chk("R2 preempt", preempt, 1);
      do_eos();
      chk("R6 next is lvl4", grant_lvl, 4);
      chk("R6 preempt lvl4", preempt, 1);
      do_eos();
      step();
      chk("R6 single pending", preempt, 0);
      chk("R6 idle", cur_valid, 0);

      // R8 mask
      set_mask(8'h02);
      pulse_hw(1);
      for (int i = 0; i < 3; i++) begin
         chk("R8 masked held", preempt, 0);
         step();
      end
      chk("R8 idle while masked", cur_valid, 0);
      set_mask(8'h00);
      chk("R8 not yet", preempt, 0);
      step();
      chk("R8 granted after unmask", preempt, 1);
      chk("R8 grant lvl1", grant_lvl, 1);
      do_eos();

      // R9 power-fail
      pulse_hw(0); step();
      chk("R9 lvl0 running", cur_lvl, 0);
      pf_req = 1'b1; step(); step();
      chk("R9 pf preempts lvl0", preempt, 1);
      chk("R9 grant_pf", grant_pf, 1);
      chk("R9 cur_pf", cur_pf, 1);
      pf_req = 1'b0;
      pulse_hw(1);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R9 no maskable grant under pf", preempt, 0);
      end
      do_eos();
      chk("R9 eos clears pf", cur_pf, 0);
      chk("R9 back to lvl0", cur_lvl, 0);
      chk("R9 no preempt", preempt, 0);
      do_eos();
      chk("R11 lvl1 on eos", preempt, 1);
      chk("R11 grant lvl1", grant_lvl, 1);
      do_eos();
      set_mask(8'hFF);
      pf_req = 1'b1; step(); step();
      chk("R9 pf unmaskable", preempt, 1);
      chk("R9 grant_pf masked", grant_pf, 1);
      pf_req = 1'b0;
      do_eos();
      chk("R9 idle", cur_valid, 0);
      set_mask(8'h00);

      // Sweep over ordered level pairs
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            if (a != b) begin
               pulse_hw(a); step();
               chk("R3 sweep first grant", grant_lvl, a);
               chk("R3 sweep first preempt", preempt, 1);
               if (((a + b) % 2) == 1) sw_trig(b); else pulse_hw(b);
               step();
               if (b < a) begin
                  chk("R3 sweep preempt", preempt, 1);
                  chk("R3 sweep grant", grant_lvl, b);
                  do_eos();
                  chk("R5 sweep resume", cur_lvl, a);
                  chk("R5 sweep no preempt", preempt, 0);
               end else begin
                  chk("R4 sweep no preempt", preempt, 0);
                  chk("R4 sweep cur", cur_lvl, a);
                  do_eos();
                  chk("R11 sweep preempt", preempt, 1);
                  chk("R11 sweep grant", grant_lvl, b);
               end
               do_eos();
               chk("R5 sweep idle", cur_valid, 0);
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule